// File: doc/BRIEF.md
# Tape Label-Skip Jump Controller

This controller sequences a program that streams from a linear medium such as punched tape. The machine has no program counter and no address bus. Each instruction read from the tape arrives as a command on a valid/ready stream. Ordinary instructions become a one-cycle execute strobe. A jump moves the tape by a signed number of label marks. The distance comes from register Q in two's complement. A negative distance runs the tape backward and a positive one runs it forward.

A jump is taken when the condition is met. The condition is built from any selection of the carry, sign and zero flags of the result register. The selected flags are ORed together, and an empty selection makes the jump unconditional. While the tape skips, the controller drains and discards the commands that pass under the read head. It counts the label-detect strobes until the distance is used up, and then returns to normal execution.

A halt command stops the tape and holds back the command stream until the operator presses a restart button. The button input is synchronised and debounced into a single pulse for each press.

Back-pressure rules: `cmd_ready` falls only while the controller is halted. In run and skip states every valid command is consumed in the cycle it is presented. A command is accepted only on a clock edge where both `cmd_valid` and `cmd_ready` are high.

Top module: `tape_jump_ctl`

## Requirements
- R1: After reset, `busy`, `halted`, `tape_dir` and `exec_strobe` are 0, and `tape_run` and `cmd_ready` are 1.
- R2: `cmd_kind` encodes the command: 0 = execute, 1 = jump, 2 = halt, 3 = no operation. An execute command accepted outside a skip raises `exec_strobe` for exactly the one cycle after the accepting edge. A no-operation command raises nothing.
- R3: `cmd_sel[2]` enables carry, `cmd_sel[1]` enables sign and `cmd_sel[0]` enables zero. A jump is taken when `cmd_sel` is 0 or when any enabled flag is 1. A jump that is not taken leaves `busy` low.
- R4: During a taken jump, `tape_dir` equals the sign bit of `cmd_q` (1 = backward) and stays constant until the skip ends. It is 0 at all other times.
- R5: A taken jump with a nonzero `cmd_q` sets `busy` after the accepting edge. `busy` clears after the edge that samples the |Q|-th `label_mark` pulse. This also holds for the most negative value.
- R6: A taken jump with `cmd_q` = 0 completes at once: `busy` stays 0 and `tape_dir` stays 0.
- R7: While `busy` is high, `cmd_ready` is 1, and the commands accepted are discarded without any `exec_strobe`.
- R8: An accepted halt command sets `halted`, drops `tape_run` and `cmd_ready`, and holds them there until a restart pulse arrives. No command is accepted while halted.
- R9: `restart_btn` takes effect only after it has been stable high for DEB_CYCLES cycles past a two-stage synchroniser. A shorter glitch is ignored. A press produces at most one restart, and a press made while running is used up without effect.
- R10: `label_mark` pulses outside a skip have no effect on later jump counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command from the tape reader is present |
| cmd_ready | output | 1 | Controller accepts a command this cycle |
| cmd_kind | input | 2 | Command encoding (see R2) |
| cmd_sel | input | 3 | Condition enables: carry, sign, zero |
| cmd_q | input | W | Signed jump distance in label marks |
| flag_c | input | 1 | Carry flag of result register |
| flag_s | input | 1 | Sign flag of result register |
| flag_z | input | 1 | Zero flag of result register |
| label_mark | input | 1 | One-cycle label-detect strobe |
| restart_btn | input | 1 | Raw restart push button |
| exec_strobe | output | 1 | Execute the accepted instruction |
| tape_run | output | 1 | Tape motor enable |
| tape_dir | output | 1 | Tape direction, 1 = backward |
| busy | output | 1 | Label skip in progress |
| halted | output | 1 | Halted, waiting for restart |

## Verification
The skip counter is the main internal state. If it is loaded or decremented wrongly, `busy` falls one or more label marks too early or too late. That error shows in the cycle right after the offending strobe. A wrong take decision or direction latch shows on `busy` and `tape_dir` one cycle after the jump is accepted. A fault in the debouncer shows as a halt that releases after a glitch, or one that releases twice for a single held press, within a few tens of cycles.

// File: rtl/tjc_pkg.sv
package tjc_pkg;
  typedef enum logic [1:0] {
    OP_EXEC = 2'd0,
    OP_JUMP = 2'd1,
    OP_HALT = 2'd2,
    OP_NOP  = 2'd3
  } op_e;

  localparam int NFLAG = 3;
endpackage

// File: rtl/tjc_cond_eval.sv
module tjc_cond_eval #(
  parameter int NF = 3
) (
  input  logic [NF-1:0] sel,
  input  logic [NF-1:0] flags,
  output logic          take
);
  logic [NF-1:0] hit;

  for (genvar i = 0; i < NF; i++) begin : g_hit
    assign hit[i] = sel[i] & flags[i];
  end

  assign take = (sel == '0) | (|hit);
endmodule

// File: rtl/tjc_skip_count.sv
module tjc_skip_count #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_q,
  input  logic         label,
  output logic         active,
  output logic         dir
);
  logic [W-1:0] cnt;
  logic [W-1:0] mag;

  always_comb mag = load_q[W-1] ? (~load_q + 1'b1) : load_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      dir    <= 1'b0;
    end else if (load) begin
      active <= 1'b1;
      cnt    <= mag;
      dir    <= load_q[W-1];
    end else if (active && label) begin
      if (cnt == W'(1)) begin
        active <= 1'b0;
        cnt    <= '0;
        dir    <= 1'b0;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  // R5
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && label && !load && cnt > W'(1)) |=> (active && cnt == $past(cnt) - 1'b1));

  // R4
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && !$past(load)) |-> $stable(dir));
endmodule

// File: rtl/tjc_restart_deb.sv
module tjc_restart_deb #(
  parameter int DEB = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic pulse
);
  localparam int CW = $clog2(DEB + 1);

  logic [1:0]    sync;
  logic          lvl;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync  <= '0;
      lvl   <= 1'b0;
      cnt   <= '0;
      pulse <= 1'b0;
    end else begin
      sync  <= {sync[0], raw};
      pulse <= 1'b0;
      if (sync[1] != lvl) begin
        if (cnt == CW'(DEB - 1)) begin
          lvl   <= sync[1];
          cnt   <= '0;
          pulse <= sync[1];
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        cnt <= '0;
      end
    end
  end

  // R9
  one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);
endmodule

// File: rtl/tape_jump_ctl.sv
module tape_jump_ctl
  import tjc_pkg::*;
#(
  parameter int W          = 8,
  parameter int DEB_CYCLES = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_valid,
  output logic         cmd_ready,
  input  logic [1:0]   cmd_kind,
  input  logic [2:0]   cmd_sel,
  input  logic [W-1:0] cmd_q,
  input  logic         flag_c,
  input  logic         flag_s,
  input  logic         flag_z,
  input  logic         label_mark,
  input  logic         restart_btn,
  output logic         exec_strobe,
  output logic         tape_run,
  output logic         tape_dir,
  output logic         busy,
  output logic         halted
);
  logic             halted_q;
  logic             exec_q;
  logic             take;
  logic             active;
  logic             dir_q;
  logic             restart_p;
  logic             accept;
  logic             run_mode;
  logic             do_exec;
  logic             do_jump;
  logic             do_halt;
  logic [NFLAG-1:0] flags;

  assign flags = {flag_c, flag_s, flag_z};

  tjc_cond_eval #(.NF(NFLAG)) u_cond (
    .sel   (cmd_sel),
    .flags (flags),
    .take  (take)
  );

  assign cmd_ready = ~halted_q;
  assign accept    = cmd_valid & cmd_ready;
  assign run_mode  = ~halted_q & ~active;
  assign do_exec   = accept & run_mode & (cmd_kind == OP_EXEC);
  assign do_jump   = accept & run_mode & (cmd_kind == OP_JUMP) & take & (cmd_q != '0);
  assign do_halt   = accept & run_mode & (cmd_kind == OP_HALT);

  tjc_skip_count #(.W(W)) u_skip (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (do_jump),
    .load_q (cmd_q),
    .label  (label_mark),
    .active (active),
    .dir    (dir_q)
  );

  tjc_restart_deb #(.DEB(DEB_CYCLES)) u_deb (
    .clk   (clk),
    .rst_n (rst_n),
    .raw   (restart_btn),
    .pulse (restart_p)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      halted_q <= 1'b0;
      exec_q   <= 1'b0;
    end else begin
      exec_q <= do_exec;
      if (do_halt)
        halted_q <= 1'b1;
      else if (halted_q && restart_p)
        halted_q <= 1'b0;
    end
  end

  assign exec_strobe = exec_q;
  assign tape_run    = ~halted_q;
  assign tape_dir    = active & dir_q;
  assign busy        = active;
  assign halted      = halted_q;

  // R2
  exec_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_strobe |-> $past(cmd_valid && cmd_ready && !busy && cmd_kind == OP_EXEC));

  // R7
  skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !$rose(busy)) |-> !exec_strobe);

  // R8
  halt_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted) |-> $past(cmd_valid && cmd_kind == OP_HALT && !busy));

  // R9
  release_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(halted) |-> $past(restart_p));
endmodule

// File: tb/tape_jump_ctl_bench.sv
module tape_jump_ctl_bench;
  localparam int W   = 4;
  localparam int DEB = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_valid = 1'b0;
  logic         cmd_ready;
  logic [1:0]   cmd_kind = 2'd0;
  logic [2:0]   cmd_sel = 3'd0;
  logic [W-1:0] cmd_q = '0;
  logic         flag_c = 1'b0, flag_s = 1'b0, flag_z = 1'b0;
  logic         label_mark = 1'b0;
  logic         restart_btn = 1'b0;
  logic         exec_strobe, tape_run, tape_dir, busy, halted;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  tape_jump_ctl #(.W(W), .DEB_CYCLES(DEB)) u_tape_jump_ctl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_kind(cmd_kind), .cmd_sel(cmd_sel), .cmd_q(cmd_q),
    .flag_c(flag_c), .flag_s(flag_s), .flag_z(flag_z),
    .label_mark(label_mark), .restart_btn(restart_btn),
    .exec_strobe(exec_strobe), .tape_run(tape_run), .tape_dir(tape_dir),
    .busy(busy), .halted(halted)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] kind, input logic [2:0] sel, input logic [W-1:0] q);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_kind = kind; cmd_sel = sel; cmd_q = q;
    @(posedge clk);
    #1 cmd_valid = 1'b0;
  endtask

  task automatic label();
    @(negedge clk);
    label_mark = 1'b1;
    @(posedge clk);
    #1 label_mark = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total + 1, bad);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    #1;
    // R1
    chk(!busy && !halted && !tape_dir && !exec_strobe, "R1 idle outputs", {busy, halted, tape_dir, exec_strobe}, 0);
    chk(tape_run && cmd_ready, "R1 run/ready", {tape_run, cmd_ready}, 3);

    // R2
    send(2'd0, 3'd0, '0);
    chk(exec_strobe == 1'b1, "R2 exec strobe", exec_strobe, 1);
    idle(1);
    chk(exec_strobe == 1'b0, "R2 single cycle", exec_strobe, 0);
    send(2'd3, 3'd0, '0);
    chk(exec_strobe == 1'b0 && !busy, "R2 nop silent", exec_strobe, 0);

    // R3 sweep of all selections and flag values
    for (int s = 0; s < 8; s++) begin
      for (int f = 0; f < 8; f++) begin
        bit exp_take;
        exp_take = (s == 0) || ((s & f) != 0);
        flag_c = f[2]; flag_s = f[1]; flag_z = f[0];
        send(2'd1, 3'(s), W'(2));
        chk(busy == exp_take, $sformatf("R3 sel=%0d flags=%0d", s, f), busy, exp_take);
        if (busy) begin
          label();
          label();
          chk(!busy, "R5 skip of 2", busy, 0);
        end
      end
    end
    flag_c = 1'b0; flag_s = 1'b0; flag_z = 1'b0;

    // R4 R5 R6 R7 sweep of all distances
    for (int qi = -8; qi < 8; qi++) begin
      int mag;
      mag = (qi < 0) ? -qi : qi;
      send(2'd1, 3'd0, W'(qi));
      if (qi == 0) begin
        chk(!busy && !tape_dir, "R6 zero jump", busy, 0);
      end else begin
        chk(busy, $sformatf("R5 busy q=%0d", qi), busy, 1);
        chk(tape_dir == (qi < 0), $sformatf("R4 dir q=%0d", qi), tape_dir, (qi < 0));
        chk(tape_run, "R4 tape moving", tape_run, 1);
        send(2'd0, 3'd0, '0);
        chk(!exec_strobe && busy, "R7 exec discarded", exec_strobe, 0);
        chk(cmd_ready, "R7 ready in skip", cmd_ready, 1);
        for (int k = 1; k < mag; k++) begin
          label();
          chk(busy && tape_dir == (qi < 0), $sformatf("R5 mid q=%0d k=%0d", qi, k), busy, 1);
        end
        label();
        chk(!busy && !tape_dir, $sformatf("R5 end q=%0d", qi), busy, 0);
      end
    end

    // R10
    label(); label(); label();
    send(2'd1, 3'd0, W'(1));
    chk(busy, "R10 jump starts", busy, 1);
    label();
    chk(!busy, "R10 count unaffected", busy, 0);

    // R8
    send(2'd2, 3'd0, '0);
    chk(halted && !tape_run && !cmd_ready, "R8 halt", {halted, tape_run, cmd_ready}, 4);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_kind = 2'd0;
    idle(3);
    chk(!exec_strobe && halted, "R8 no accept while halted", exec_strobe, 0);
    cmd_valid = 1'b0;

    // R9 glitch
    @(negedge clk); restart_btn = 1'b1;
    idle(2);
    @(negedge clk); restart_btn = 1'b0;
    idle(12);
    chk(halted, "R9 glitch ignored", halted, 1);
    // R9 real press
    @(negedge clk); restart_btn = 1'b1;
    idle(15);
    chk(!halted && tape_run, "R9 restart", halted, 0);
    send(2'd2, 3'd0, '0);
    idle(12);
    chk(halted, "R9 one release per press", halted, 1);
    @(negedge clk); restart_btn = 1'b0;
    idle(12);
    @(negedge clk); restart_btn = 1'b1;
    idle(15);
    chk(!halted, "R9 second press", halted, 0);
    @(negedge clk); restart_btn = 1'b0;
    idle(12);
    @(negedge clk); restart_btn = 1'b1;
    idle(15);
    send(2'd2, 3'd0, '0);
    idle(12);
    chk(halted, "R9 press while running used up", halted, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule